// File: doc/BRIEF.md
# UART Modem Handshake Section

This block is the modem-handshake part of a 16550-style serial controller. It watches four active-low handshake lines from the modem: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer before any edge detection. A status register reports the current asserted level of each line and a sticky flag for each change since the status register was last read. A control register drives the active-low data-terminal-ready and request-to-send outputs and selects an internal loopback mode for self-test.

The host reaches two registers through a simple port. Address 0 is the control register, which can be read and written. Address 1 is the status register, which is read-only; a read strobe on it clears the change flags. A modem-status interrupt request is raised while any change flag is set and the interrupt enable input is high. The interrupt priority logic, the data path and the host bus protocol sit outside this block.

Top module: `uart_modem_port`

## Requirements
- R1: A level change on a modem input shows in the status register's current-level bits after exactly SYNC_STAGES rising clock edges.
- R2: Status bits 4, 5, 6 and 7 read 1 while clear-to-send, data-set-ready, ring indicator and carrier detect (respectively) are driven low, and read 0 while they are high.
- R3: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) are set one clock edge after the matching level bit changes in either direction, and stay set until cleared.
- R4: Status bit 2 is set only when the ring-indicator level bit goes from 1 to 0 (the end of a ring), never when it goes from 0 to 1.
- R5: A read strobe with address 1 clears bits 3:0 of the status register at that clock edge, except that a flag whose line changes in that same cycle stays set.
- R6: Outside loop mode, the data-terminal-ready output is low exactly when control bit 0 is 1, and the request-to-send output is low exactly when control bit 1 is 1.
- R7: With control bit 4 set (loop mode), both handshake outputs are high, the external inputs are ignored, and the level bits take clear-to-send from control bit 1, data-set-ready from control bit 0, ring indicator from control bit 2 and carrier detect from control bit 3.
- R8: The interrupt request is high exactly when the interrupt enable input is high and at least one of status bits 3:0 is 1.
- R9: Reading address 0 returns the last five bits written to it in bits 4:0 and zeros in bits 7:5; a write to address 1 changes no register.
- R10: After reset the control register is 0, all change flags are 0 and both handshake outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctsN | input | 1 | Clear-to-send from modem, active low |
| dsrN | input | 1 | Data-set-ready from modem, active low |
| riN | input | 1 | Ring indicator from modem, active low |
| dcdN | input | 1 | Carrier detect from modem, active low |
| regAddr | input | 1 | Register select: 0 control, 1 status |
| regWe | input | 1 | Write strobe |
| regRe | input | 1 | Read strobe (clears flags when address is 1) |
| regWdata | input | 8 | Write data |
| msiEn | input | 1 | Modem-status interrupt enable |
| regRdata | output | 8 | Read data of the selected register |
| dtrN | output | 1 | Data-terminal-ready to modem, active low |
| rtsN | output | 1 | Request-to-send to modem, active low |
| msiReq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2, so the latency check of R1 sees a depth the default does not cover and a reference model tuned to a two-flop chain would disagree. With this depth a read strobe can be placed in the exact cycle where a synchronized change reaches the edge detector, which exercises the collision case of R5. Loop mode is entered and left while the external lines are moving, so both the ignore rule and the flags produced by the switch of source are exercised.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int REG_W      = 8;
  localparam int LINE_CNT   = 4;
  localparam int CTL_W      = 5;
  // line order inside level/flag nibbles
  localparam int LN_CTS     = 0;
  localparam int LN_DSR     = 1;
  localparam int LN_RI      = 2;
  localparam int LN_DCD     = 3;
  // control register bits
  localparam int CB_DTR     = 0;
  localparam int CB_RTS     = 1;
  localparam int CB_LPRI    = 2;
  localparam int CB_LPDCD   = 3;
  localparam int CB_LOOP    = 4;
  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef struct packed {
    logic wrCtl;
    logic rdStat;
  } modemStrobe_t;
endpackage

// File: rtl/uart_modem_sync.sv
module uart_modem_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= {WIDTH{RST_VAL}};
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import uart_modem_pkg::*;
(
  input  logic         regAddr,
  input  logic         regWe,
  input  logic         regRe,
  output modemStrobe_t stb
);
  always_comb begin
    stb.wrCtl  = regWe && (regAddr == ADDR_CTL);
    stb.rdStat = regRe && (regAddr == ADDR_STAT);
  end
endmodule

// File: rtl/uart_modem_datapath.sv
module uart_modem_datapath
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  modemStrobe_t       stb,
  input  logic               rdSel,
  input  logic [REG_W-1:0]   wData,
  input  logic [LINE_CNT-1:0] lineN,
  input  logic               msiEn,
  output logic [REG_W-1:0]   rdData,
  output logic               dtrN,
  output logic               rtsN,
  output logic               msiReq
);
  logic [LINE_CNT-1:0] syncN;
  logic [LINE_CNT-1:0] loopLvl;
  logic [LINE_CNT-1:0] curLvl;
  logic [LINE_CNT-1:0] prevLvl;
  logic [LINE_CNT-1:0] chg;
  logic [LINE_CNT-1:0] flags;
  logic [CTL_W-1:0]    ctlReg;
  logic                loopMode;

  uart_modem_sync #(
    .WIDTH  (LINE_CNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (lineN),
    .dout(syncN)
  );

  assign loopMode = ctlReg[CB_LOOP];

  always_comb begin
    loopLvl         = '0;
    loopLvl[LN_CTS] = ctlReg[CB_RTS];
    loopLvl[LN_DSR] = ctlReg[CB_DTR];
    loopLvl[LN_RI]  = ctlReg[CB_LPRI];
    loopLvl[LN_DCD] = ctlReg[CB_LPDCD];
  end

  assign curLvl = loopMode ? loopLvl : ~syncN;

  generate
    for (genvar g = 0; g < LINE_CNT; g++) begin : g_edge
      if (g == LN_RI) begin : g_trail
        assign chg[g] = prevLvl[g] & ~curLvl[g];
      end else begin : g_any
        assign chg[g] = prevLvl[g] ^ curLvl[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= '0;
      flags   <= '0;
      ctlReg  <= '0;
    end else begin
      prevLvl <= curLvl;
      flags   <= (stb.rdStat ? '0 : flags) | chg;
      if (stb.wrCtl) ctlReg <= wData[CTL_W-1:0];
    end
  end

  assign dtrN   = ~(ctlReg[CB_DTR] & ~loopMode);
  assign rtsN   = ~(ctlReg[CB_RTS] & ~loopMode);
  assign msiReq = msiEn & (|flags);
  assign rdData = (rdSel == ADDR_STAT) ? {curLvl, flags}
                                       : {{(REG_W-CTL_W){1'b0}}, ctlReg};

  // flags persist when no read clears them
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStat |=> ((flags & $past(flags)) == $past(flags)));

  // a read with no concurrent change empties the flags
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStat && chg == '0) |=> (flags == '0));

  // ring flag only rises on the falling edge of the ring level
  assert_ri_trailing_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[LN_RI]) |-> $fell(prevLvl[LN_RI]));

  // entering loop mode releases both handshake outputs
  assert_loop_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loopMode) |-> (dtrN && rtsN));

  // a write aimed at the status address leaves control untouched
  assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCtl |=> $stable(ctlReg));
endmodule

// File: rtl/uart_modem_port.sv
module uart_modem_port
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       regAddr,
  input  logic       regWe,
  input  logic       regRe,
  input  logic [7:0] regWdata,
  input  logic       msiEn,
  output logic [7:0] regRdata,
  output logic       dtrN,
  output logic       rtsN,
  output logic       msiReq
);
  modemStrobe_t        stb;
  logic [LINE_CNT-1:0] lineN;

  always_comb begin
    lineN         = '1;
    lineN[LN_CTS] = ctsN;
    lineN[LN_DSR] = dsrN;
    lineN[LN_RI]  = riN;
    lineN[LN_DCD] = dcdN;
  end

  uart_modem_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .regRe  (regRe),
    .stb    (stb)
  );

  uart_modem_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdSel (regAddr),
    .wData (regWdata),
    .lineN (lineN),
    .msiEn (msiEn),
    .rdData(regRdata),
    .dtrN  (dtrN),
    .rtsN  (rtsN),
    .msiReq(msiReq)
  );
endmodule

// File: tb/uart_modem_port_bench.sv
module uart_modem_port_bench;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic regAddr = 1'b0, regWe = 1'b0, regRe = 1'b0, msiEn = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic dtrN, rtsN, msiReq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_port #(.SYNC_STAGES(SYNC)) u_uart_modem_port (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .regAddr(regAddr), .regWe(regWe), .regRe(regRe), .regWdata(regWdata),
    .msiEn(msiEn), .regRdata(regRdata), .dtrN(dtrN), .rtsN(rtsN), .msiReq(msiReq)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0] mQ[$];          // synchronizer contents, newest at front
  logic [3:0] mPrev = 4'h0;   // previous levels {dcd,ri,dsr,cts}
  logic [3:0] mFlag = 4'h0;
  logic [4:0] mCtl  = 5'h0;

  function automatic logic [3:0] mLevels();
    if (mCtl[4]) return {mCtl[3], mCtl[2], mCtl[0], mCtl[1]};
    return ~mQ[$];
  endfunction

  task automatic mReset();
    mQ.delete();
    for (int i = 0; i < SYNC; i++) mQ.push_back(4'hF);
    mPrev = 4'h0; mFlag = 4'h0; mCtl = 5'h0;
  endtask

  initial mReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mReset();
    else begin
      logic [3:0] lv, ch;
      lv = mLevels();
      ch[0] = lv[0] != mPrev[0];
      ch[1] = lv[1] != mPrev[1];
      ch[2] = mPrev[2] && !lv[2];
      ch[3] = lv[3] != mPrev[3];
      mFlag = ((regRe && regAddr) ? 4'h0 : mFlag) | ch;
      mPrev = lv;
      if (regWe && !regAddr) mCtl = regWdata[4:0];
      mQ.push_front({dcdN, riN, dsrN, ctsN});
      void'(mQ.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R6 R7 dtr", {7'h0, dtrN}, {7'h0, !(mCtl[0] && !mCtl[4])});
      chk("R6 R7 rts", {7'h0, rtsN}, {7'h0, !(mCtl[1] && !mCtl[4])});
      chk("R8 irq", {7'h0, msiReq}, {7'h0, msiEn && (mFlag != 0)});
      if (regAddr) chk("R1 R2 R3 R4 R5 status", regRdata, {mLevels(), mFlag});
      else         chk("R9 control", regRdata, {3'b000, mCtl});
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic wrCtl(input logic [7:0] v);
    regAddr = 1'b0; regWe = 1'b1; regWdata = v;
    cyc();
    regWe = 1'b0;
  endtask

  task automatic rdStat();
    regAddr = 1'b1; regRe = 1'b1;
    cyc();
    regRe = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    #1;
    chk("R10 control", regRdata, 8'h00);
    chk("R10 dtr", {7'h0, dtrN}, 8'h01);
    chk("R10 rts", {7'h0, rtsN}, 8'h01);
    cyc();

    wrCtl(8'h03);
    chk("R6 dtr asserted", {7'h0, dtrN}, 8'h00);
    chk("R6 rts asserted", {7'h0, rtsN}, 8'h00);
    chk("R9 readback", regRdata, 8'h03);
    wrCtl(8'hE2);
    chk("R9 upper bits zero", regRdata, 8'h02);
    chk("R6 dtr released", {7'h0, dtrN}, 8'h01);
    wrCtl(8'h03);

    regAddr = 1'b1;
    #1 chk("R2 idle status", regRdata, 8'h00);
    ctsN = 1'b0;
    cyc(SYNC - 1);
    chk("R1 not yet", regRdata, 8'h00);
    cyc();
    chk("R1 R2 cts level", regRdata, 8'h10);
    cyc();
    chk("R3 cts flag", regRdata, 8'h11);
    chk("R8 disabled", {7'h0, msiReq}, 8'h00);
    msiEn = 1'b1;
    #1 chk("R8 enabled", {7'h0, msiReq}, 8'h01);
    rdStat();
    chk("R5 cleared", regRdata, 8'h10);
    chk("R8 after clear", {7'h0, msiReq}, 8'h00);

    riN = 1'b0;
    cyc(SYNC + 1);
    chk("R4 ring start no flag", regRdata, 8'h50);
    riN = 1'b1;
    cyc(SYNC);
    chk("R4 ring level gone", regRdata, 8'h10);
    cyc();
    chk("R4 ring end flag", regRdata, 8'h14);
    rdStat();

    dcdN = 1'b0;
    cyc(SYNC);
    chk("R2 dcd level", regRdata, 8'h90);
    rdStat();
    chk("R5 collision kept", regRdata, 8'h98);
    rdStat();
    chk("R5 cleared again", regRdata, 8'h90);

    wrCtl(8'h15);
    chk("R7 dtr held", {7'h0, dtrN}, 8'h01);
    chk("R7 rts held", {7'h0, rtsN}, 8'h01);
    regAddr = 1'b1;
    cyc();
    chk("R7 loop levels", regRdata, 8'h6B);
    ctsN = 1'b1; dsrN = 1'b0;
    cyc(SYNC + 1);
    chk("R7 inputs ignored", regRdata, 8'h6B);

    regWe = 1'b1; regWdata = 8'hFF;
    cyc();
    regWe = 1'b0; regAddr = 1'b0;
    #1 chk("R9 status write ignored", regRdata, 8'h15);

    wrCtl(8'h03);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      ctsN = r[0]; dsrN = r[1]; riN = r[2]; dcdN = r[3];
      regAddr = r[4]; regRe = (r[7:5] == 0);
      regWe = (r[10:8] == 0); regWdata = r[23:16] & ((r[14:11] == 0) ? 8'hFF : 8'hEF);
      msiEn = r[24];
      cyc();
    end
    regWe = 1'b0; regRe = 1'b0;
    cyc(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule